// File: doc/BRIEF.md
# Accelerometer Sample Set Buffer

This block holds three-axis acceleration sample sets (X, Y, Z) from a sensing path until a host drains them in bursts. Samples arrive on a valid/ready stream and leave on a second valid/ready stream, one whole set per transfer. A single storage array serves four buffering policies that differ in how a full buffer treats new data and in which set a read returns. The policies are: stop-when-full queue, oldest-dropping stream, trigger capture with a programmable pre-trigger history, and newest-first stack.

Each axis is kept either at full 16-bit precision or reduced to its upper byte. Reduced sets pack more densely, so the buffer holds 681 sets at low resolution and 339 at high resolution. The threshold is given as a low byte plus two high bits. It serves two purposes: it sets the watermark level, and in trigger mode it sets the depth of the history kept before the trigger. The fill level is reported as a low byte plus three high bits.

Stream rules: a set is taken on a clock edge where `in_valid` and `in_ready` are both high. A set is removed on an edge where `out_valid` and `out_ready` are both high. `out_valid` is high whenever the level is non-zero. The producer may hold `in_valid` while `in_ready` is low. A sensor that cannot stall simply loses that set. The consumer may raise `out_ready` at any time.

Top module: `accel_sample_buffer`

## Requirements
- R1: After reset the level is 0, `out_valid`, `wm_flag`, `full_flag` and `trig_flag` are low, and the output axes read 0.
- R2: Mode code 2'b00 (queue): reads return the oldest set first. At capacity `in_ready` is low and offered sets are not stored. After a read frees space, sets are accepted again.
- R3: Capacity is 681 sets when `res_hi` is 0 and 339 sets when `res_hi` is 1. `full_flag` is high exactly when the level equals the capacity, so a read clears it.
- R4: Mode code 2'b01 (stream): `in_ready` stays high. A push into a full buffer discards the oldest set, and reads return the oldest set first.
- R5: Mode code 2'b11 (stack): `in_ready` stays high. A push into a full buffer discards the oldest set, and reads return the most recently stored set first.
- R6: Mode code 2'b10 (trigger): before the trigger the buffer keeps only the newest T sets, where T is the threshold; `in_ready` is low when T is 0. A `trig` pulse sets `trig_flag`. After that, sets are stored until the buffer is full, and then only while space exists. Reads return the oldest set first.
- R7: The threshold T is {`wm_hi`,`wm_lo`}. `wm_flag` is high when T is non-zero and the level is at least T, and it drops once reads bring the level below T.
- R8: The level reads as {`lvl_hi`,`lvl_lo`}, an 11-bit count of stored sets.
- R9: With `res_hi`=0 each axis keeps bits 15:8 and reads back with bits 7:0 zero. With `res_hi`=1 all 16 bits are kept.
- R10: A one-cycle `clr` empties the buffer: after that edge the level is 0 and `trig_flag`, `full_flag` and `wm_flag` are low.
- R11: A read request on an empty buffer shows zeros and leaves the level at 0. A push and a pop on the same edge into a non-full buffer leave the level unchanged; in stack mode the pop returns the set that was newest before the push.
- R12: While `en` is high, any change of `mode` or `res_hi` empties the buffer and clears `trig_flag`. While `en` is low, `in_ready` is low and the contents are kept.
- R13: `out_valid` equals (level != 0). The presented set is the one the next pop removes, and it is held until a pop or push changes the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Buffer enable |
| clr | input | 1 | Single-cycle flush strobe |
| res_hi | input | 1 | 1: 16-bit axes, 0: 8-bit axes |
| mode | input | 2 | 00 queue, 01 stream, 10 trigger, 11 stack |
| wm_lo | input | 8 | Threshold bits 7:0 |
| wm_hi | input | 2 | Threshold bits 9:8 |
| trig | input | 1 | Trigger event (trigger mode only) |
| in_valid | input | 1 | Input set valid |
| in_ready | output | 1 | Input set accepted on this edge if valid |
| in_x | input | 16 | X sample |
| in_y | input | 16 | Y sample |
| in_z | input | 16 | Z sample |
| out_valid | output | 1 | A set is available |
| out_ready | input | 1 | Consumer pops the presented set |
| out_x | output | 16 | X of the presented set |
| out_y | output | 16 | Y of the presented set |
| out_z | output | 16 | Z of the presented set |
| lvl_lo | output | 8 | Level bits 7:0 |
| lvl_hi | output | 3 | Level bits 10:8 |
| wm_flag | output | 1 | Level at or above threshold |
| full_flag | output | 1 | Level at capacity |
| trig_flag | output | 1 | Trigger seen since the last flush |

## Verification
The assertions check several rules on every cycle. The level never exceeds the larger capacity, and a full queue never signals ready. A flush leaves the buffer empty, and a simultaneous push and pop keep the level. Popping an empty buffer does nothing, a full stream stays full while it is fed, and the trigger flag rises only on a trigger in trigger mode. Data ordering can only be shown by the bench's scenarios, which compare every popped set against a reference queue. These cover oldest-first against newest-first reads, which set is discarded on overflow, the pre-trigger history depth, the resolution packing and the watermark crossing at a threshold above 255.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    SB_QUEUE  = 2'b00,
    SB_STREAM = 2'b01,
    SB_TRIG   = 2'b10,
    SB_STACK  = 2'b11
  } sb_mode_e;
endpackage

// File: rtl/sbuf_pack.sv
module sbuf_pack #(
  parameter int DW  = 16,
  parameter int NAX = 3
) (
  input  logic              res_hi,
  input  logic [NAX*DW-1:0] raw,
  output logic [NAX*DW-1:0] packed_set
);
  localparam int HW = DW / 2;
  for (genvar a = 0; a < NAX; a++) begin : g_axis
    // low resolution keeps only the upper half of each axis
    assign packed_set[a*DW +: DW] = res_hi ? raw[a*DW +: DW]
                                           : {raw[a*DW+HW +: DW-HW], {HW{1'b0}}};
  end
endmodule

// File: rtl/sbuf_mem.sv
module sbuf_mem #(
  parameter int W     = 48,
  parameter int DEPTH = 681,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] store [DEPTH];
  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
  end
  assign rd = store[ra];
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int CAP_LO = 681,
  parameter int CAP_HI = 339,
  parameter int AW     = 10,
  parameter int LW     = 11,
  parameter int TW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          res_hi,
  input  sb_mode_e      mode,
  input  logic [TW-1:0] thresh,
  input  logic          trig,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] level,
  output logic          is_full,
  output logic          triggered
);
  localparam logic [LW-1:0] CAP_L = LW'(CAP_LO);
  localparam logic [LW-1:0] CAP_H = LW'(CAP_HI);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p, input logic [AW-1:0] last);
    return (p == last) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [AW-1:0] prv(input logic [AW-1:0] p, input logic [AW-1:0] last);
    return (p == '0) ? last : p - 1'b1;
  endfunction

  logic [AW-1:0] head, tail, head_m1, last_addr;
  logic [LW-1:0] cap, thr_l;
  sb_mode_e      mode_q;
  logic          res_q, flush, push, pop, drop, stack_m, drop_mode;

  assign cap       = res_hi ? CAP_H : CAP_L;
  assign last_addr = AW'(cap - LW'(1));
  assign thr_l     = LW'(thresh);
  assign flush     = clr | (en & ((mode != mode_q) | (res_hi != res_q)));
  assign is_full   = (level >= cap);
  assign stack_m   = (mode == SB_STACK);
  assign head_m1   = prv(head, last_addr);

  always_comb begin
    in_ready = 1'b0;
    if (en && !flush) begin
      unique case (mode)
        SB_QUEUE:  in_ready = !is_full;
        SB_STREAM: in_ready = 1'b1;
        SB_STACK:  in_ready = 1'b1;
        SB_TRIG:   in_ready = triggered ? !is_full : (thr_l != '0);
        default:   in_ready = 1'b0;
      endcase
    end
  end

  assign out_valid = (level != '0) && !flush;
  assign push      = in_valid && in_ready;
  assign pop       = out_ready && out_valid;
  // overflow policy: which modes discard the oldest set
  assign drop_mode = ((mode == SB_STREAM || stack_m) && is_full) ||
                     (mode == SB_TRIG && !triggered && level >= thr_l);
  assign drop      = push && !pop && drop_mode;

  assign rd_addr = stack_m ? head_m1 : tail;
  assign wr_en   = push;
  assign wr_addr = (stack_m && pop) ? head_m1 : head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      level     <= '0;
      triggered <= 1'b0;
      mode_q    <= SB_QUEUE;
      res_q     <= 1'b0;
    end else begin
      mode_q <= mode;
      res_q  <= res_hi;
      if (flush) begin
        head      <= '0;
        tail      <= '0;
        level     <= '0;
        triggered <= 1'b0;
      end else begin
        if (push && !(stack_m && pop))      head <= nxt(head, last_addr);
        else if (stack_m && pop && !push)   head <= head_m1;
        if ((!stack_m && pop) || drop)      tail <= nxt(tail, last_addr);
        level <= level + LW'(push) - LW'(pop) - LW'(drop);
        if (en && mode == SB_TRIG && trig)  triggered <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/accel_sample_buffer.sv
module accel_sample_buffer
  import sbuf_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CAP_LO = 681,
  parameter int CAP_HI = 339,
  parameter int TW     = 10,
  parameter int LW     = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic            res_hi,
  input  logic [1:0]      mode,
  input  logic [7:0]      wm_lo,
  input  logic [TW-9:0]   wm_hi,
  input  logic            trig,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_x,
  input  logic [DW-1:0]   in_y,
  input  logic [DW-1:0]   in_z,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_x,
  output logic [DW-1:0]   out_y,
  output logic [DW-1:0]   out_z,
  output logic [7:0]      lvl_lo,
  output logic [LW-9:0]   lvl_hi,
  output logic            wm_flag,
  output logic            full_flag,
  output logic            trig_flag
);
  localparam int AW  = $clog2(CAP_LO);
  localparam int NAX = 3;
  localparam int SW  = NAX * DW;

  logic [TW-1:0] thresh;
  logic [LW-1:0] level;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [SW-1:0] wr_set, rd_set;
  logic          wr_en;

  assign thresh = {wm_hi, wm_lo};

  sbuf_pack #(.DW(DW), .NAX(NAX)) u_pack (
    .res_hi(res_hi), .raw({in_x, in_y, in_z}), .packed_set(wr_set)
  );

  sbuf_ctrl #(.CAP_LO(CAP_LO), .CAP_HI(CAP_HI), .AW(AW), .LW(LW), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .res_hi(res_hi),
    .mode(sb_mode_e'(mode)), .thresh(thresh), .trig(trig),
    .in_valid(in_valid), .in_ready(in_ready), .out_ready(out_ready),
    .out_valid(out_valid), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .level(level), .is_full(full_flag), .triggered(trig_flag)
  );

  sbuf_mem #(.W(SW), .DEPTH(CAP_LO), .AW(AW)) u_mem (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_set), .ra(rd_addr), .rd(rd_set)
  );

  assign {out_x, out_y, out_z} = out_valid ? rd_set : '0;
  assign {lvl_hi, lvl_lo}      = level;
  assign wm_flag               = (thresh != '0) && (level >= LW'(thresh));
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk
  import sbuf_pkg::*;
#(
  parameter int CAP_LO = 681,
  parameter int LW     = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          clr,
  input logic          res_hi,
  input logic [1:0]    mode,
  input logic          trig,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] level,
  input logic          full_flag,
  input logic          trig_flag
);
  logic [1:0] mode_p;
  logic       res_p, cfg_same;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_p <= 2'b00;
      res_p  <= 1'b0;
    end else begin
      mode_p <= mode;
      res_p  <= res_hi;
    end
  end
  assign cfg_same = !en || (mode == mode_p && res_hi == res_p);

  a_r3_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(CAP_LO));

  a_r2_queue_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SB_QUEUE && full_flag) |-> !in_ready);

  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0 && !trig_flag && !full_flag));

  a_r11_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid && !(in_valid && in_ready) && !clr && cfg_same)
      |=> $stable(level));

  a_r11_pushpop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready && !clr && cfg_same)
      |=> $stable(level));

  a_r4_stream_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SB_STREAM && full_flag && in_valid && in_ready && !out_ready && !clr && cfg_same)
      |=> full_flag);

  a_r6_trig_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_flag) |-> ($past(mode) == SB_TRIG && $past(trig)));

  a_r12_disabled_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !in_ready);
endmodule

bind accel_sample_buffer sbuf_chk #(.CAP_LO(CAP_LO), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .res_hi(res_hi), .mode(mode),
  .trig(trig), .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .level({lvl_hi, lvl_lo}), .full_flag(full_flag),
  .trig_flag(trig_flag)
);

// File: tb/tb_accel_sample_buffer.sv
`timescale 1ns/1ps
module tb_accel_sample_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, clr = 0, res_hi = 0, trig = 0, in_valid = 0, out_ready = 0;
  logic [1:0] mode = 2'b00;
  logic [7:0] wm_lo = 0;
  logic [1:0] wm_hi = 0;
  logic [15:0] in_x = 0, in_y = 0, in_z = 0;
  logic in_ready, out_valid, wm_flag, full_flag, trig_flag;
  logic [15:0] out_x, out_y, out_z;
  logic [7:0] lvl_lo;
  logic [2:0] lvl_hi;

  accel_sample_buffer dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .res_hi(res_hi), .mode(mode),
    .wm_lo(wm_lo), .wm_hi(wm_hi), .trig(trig), .in_valid(in_valid),
    .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y),
    .out_z(out_z), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .wm_flag(wm_flag),
    .full_flag(full_flag), .trig_flag(trig_flag)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, seq = 0;
  logic [47:0] q[$];
  logic [1:0] mode_m = 2'b00;
  bit hi_m = 0, en_m = 0, trg_m = 0;
  int thr_m = 0;
  bit last_acc, last_ov;
  logic [47:0] last_od;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cap_m();
    return hi_m ? 339 : 681;
  endfunction

  function automatic logic [47:0] mk(input int n);
    logic [15:0] a, b, c;
    a = 16'(n * 7 + 16'h1183);
    b = 16'(n * 13) ^ 16'h5A5A;
    c = 16'(n * 29 + 16'h0F0F);
    return {a, b, c};
  endfunction

  function automatic logic [47:0] pk(input logic [47:0] d);
    return hi_m ? d : {d[47:40], 8'h00, d[31:24], 8'h00, d[15:8], 8'h00};
  endfunction

  function automatic bit exp_rdy(input int l);
    if (!en_m) return 0;
    case (mode_m)
      2'b00:   return l < cap_m();
      2'b10:   return trg_m ? (l < cap_m()) : (thr_m != 0);
      default: return 1;
    endcase
  endfunction

  function automatic string mtag();
    case (mode_m)
      2'b00:   return "R2 queue order";
      2'b01:   return "R4 stream order";
      2'b10:   return "R6 trigger order";
      default: return "R5 stack order";
    endcase
  endfunction

  // driver + monitor for one cycle; reference queue is the scoreboard
  task automatic step(input bit push, input bit pop, input logic [47:0] d);
    int l0;
    bit popped;
    logic [47:0] e;
    @(negedge clk);
    in_valid = push; {in_x, in_y, in_z} = d; out_ready = pop;
    #1;
    last_acc = in_ready; last_ov = out_valid; last_od = {out_x, out_y, out_z};
    @(posedge clk); #1;
    in_valid = 0; out_ready = 0;
    l0 = q.size(); popped = 0;
    chk("R13 out_valid", 64'(last_ov), 64'(l0 != 0));
    if (push) chk("R13 in_ready", 64'(last_acc), 64'(exp_rdy(l0)));
    if (pop && last_ov) begin
      e = (mode_m == 2'b11) ? q[$] : q[0];
      chk(mtag(), 64'(last_od), 64'(e));
      if (mode_m == 2'b11) void'(q.pop_back()); else void'(q.pop_front());
      popped = 1;
    end
    if (push && last_acc) begin
      if (!popped && ((((mode_m == 2'b01) || (mode_m == 2'b11)) && l0 == cap_m()) ||
                      (mode_m == 2'b10 && !trg_m && l0 >= thr_m)))
        void'(q.pop_front());
      q.push_back(pk(d));
    end
    chk("R8 level", 64'({lvl_hi, lvl_lo}), 64'(q.size()));
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin step(1, 0, mk(seq)); seq++; end
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) step(0, 1, '0);
  endtask

  task automatic setcfg(input logic [1:0] m, input bit h);
    @(negedge clk); mode = m; res_hi = h;
    @(posedge clk); #1;
    mode_m = m; hi_m = h; q.delete(); trg_m = 0;
    chk("R12 cfg change level", 64'({lvl_hi, lvl_lo}), 64'd0);
    chk("R12 cfg change trig_flag", 64'(trig_flag), 64'd0);
  endtask

  task automatic setthr(input int t);
    @(negedge clk); {wm_hi, wm_lo} = 10'(t); thr_m = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int l;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 level", 64'({lvl_hi, lvl_lo}), 0);
    chk("R1 out_valid", 64'(out_valid), 0);
    chk("R1 flags", 64'({wm_flag, full_flag, trig_flag}), 0);
    chk("R1 out data", 64'({out_x, out_y, out_z}), 0);
    @(negedge clk); en = 1; en_m = 1;

    // queue, low resolution
    push_n(5);
    #1 chk("R9 low byte zero", 64'({out_x[7:0], out_y[7:0], out_z[7:0]}), 0);
    pop_n(5);
    step(0, 1, '0);
    chk("R11 empty pop data", 64'(last_od), 0);
    push_n(681);
    chk("R3 full at 681", 64'(full_flag), 1);
    step(1, 0, mk(9999));
    chk("R2 full refuses", 64'(last_acc), 0);
    pop_n(1);
    chk("R3 full clears on read", 64'(full_flag), 0);
    push_n(1);
    chk("R2 accepts after read", 64'(last_acc), 1);
    pop_n(681);

    // presented set held without pop
    push_n(2);
    step(0, 0, '0);
    chk("R13 held set", 64'(last_od), 64'(q[0]));
    pop_n(2);

    // flush strobe
    push_n(3);
    @(negedge clk); clr = 1;
    @(posedge clk); #1; clr = 0; q.delete();
    chk("R10 level", 64'({lvl_hi, lvl_lo}), 0);
    chk("R10 flags", 64'({out_valid, full_flag, wm_flag, trig_flag}), 0);

    // stream, high resolution
    setcfg(2'b01, 1);
    push_n(345);
    chk("R3 full at 339", 64'(full_flag), 1);
    chk("R4 level capped", 64'({lvl_hi, lvl_lo}), 339);
    #1 chk("R9 full precision", 64'({out_x, out_y, out_z}), 64'(q[0]));
    pop_n(339);

    // stack, low resolution
    setcfg(2'b11, 0);
    push_n(4);
    pop_n(2);
    l = q.size();
    step(1, 1, mk(seq)); seq++;
    chk("R11 push+pop level", 64'({lvl_hi, lvl_lo}), 64'(l));
    pop_n(2);
    push_n(684);
    chk("R5 level capped", 64'({lvl_hi, lvl_lo}), 681);
    pop_n(681);

    // trigger, high resolution, history of 4
    setcfg(2'b10, 1);
    setthr(4);
    push_n(10);
    chk("R6 pre-trigger history", 64'({lvl_hi, lvl_lo}), 4);
    chk("R7 watermark at T", 64'(wm_flag), 1);
    chk("R6 not yet triggered", 64'(trig_flag), 0);
    @(negedge clk); trig = 1;
    @(posedge clk); #1; trig = 0; trg_m = 1;
    chk("R6 trig_flag", 64'(trig_flag), 1);
    push_n(340);
    chk("R6 stops when full", 64'(last_acc), 0);
    chk("R6 level full", 64'({lvl_hi, lvl_lo}), 339);
    pop_n(339);

    // watermark above one byte, queue
    setcfg(2'b00, 0);
    setthr(258);
    push_n(257);
    chk("R7 below T", 64'(wm_flag), 0);
    chk("R8 split level", 64'({lvl_hi, lvl_lo}), {3'd1, 8'd1});
    push_n(1);
    chk("R7 reaches T", 64'(wm_flag), 1);
    pop_n(1);
    chk("R7 clears below T", 64'(wm_flag), 0);
    pop_n(257);
    setthr(0);

    // disabled
    push_n(2);
    @(negedge clk); en = 0; en_m = 0;
    step(1, 0, mk(seq)); seq++;
    chk("R12 disabled refuses", 64'(last_acc), 0);
    chk("R12 disabled keeps", 64'({lvl_hi, lvl_lo}), 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule